// File: doc/BRIEF.md
# Synchronous rectifier gate controller

This block decides when the two rectifier switches on the secondary side of an isolated push-pull or bridge converter may conduct. The two switches are called E and F. The primary side sends a three-level timing signal across a small transformer. Comparators outside this block turn that signal into two digital flags: `sync_pos` for a positive pulse and `sync_neg` for a negative pulse. When neither flag is set, the signal is at zero. At the zero level both switches conduct. A positive pulse turns E off and a negative pulse turns F off. Pulses must alternate in polarity, with a zero phase between them.

Three protections run alongside the sequencer:
- **Missing-sync watchdog.** It restarts whenever the sync level changes and shuts both gates if the level stays the same for too long.
- **Reverse-current trip.** Each switch has a trip flag. The trip is ignored during a blanking window after that switch's gate turns on. After the window, a trip shuts only that gate.
- **Undervoltage lockout.** It holds both gates off.

A sticky three-bit fault word records what went wrong. Both interval lengths are cycle-count parameters (`BLANK_CYC`, `TIMEOUT_CYC`).

The sequencer has six states:
- `S_WAIT_NEG`: both gates off, waiting for a negative pulse.
- `S_WAIT_ZERO`: negative pulse seen, both gates off.
- `S_ON_EXP_POS`: both gates on, a positive pulse is expected next.
- `S_POS`: E off, F on.
- `S_ON_EXP_NEG`: both gates on, a negative pulse is expected next.
- `S_NEG`: F off, E on.

The normal transitions are:
- arm: `S_WAIT_NEG` to `S_WAIT_ZERO` on a negative pulse.
- start: `S_WAIT_ZERO` to `S_ON_EXP_POS` on zero.
- e_off: `S_ON_EXP_POS` to `S_POS`.
- e_on: `S_POS` to `S_ON_EXP_NEG`.
- f_off: `S_ON_EXP_NEG` to `S_NEG`.
- f_on: `S_NEG` to `S_ON_EXP_POS`.

The abort transition, from any state to `S_WAIT_NEG`, is taken on an ordering error, a timeout or undervoltage.

Top module: `sr_gate_ctrl`

## Requirements
- R1: After reset both gates are off and `fault` is 0. A positive pulse or a zero level in `S_WAIT_NEG` is ignored, with no fault. Only a negative pulse followed by zero enables the gates.
- R2: A zero level sampled in `S_WAIT_ZERO` turns both gates on from the next clock cycle.
- R3: A positive pulse sampled while both gates are on turns E off and leaves F on from the next cycle. The zero level that follows turns E on again.
- R4: A negative pulse sampled after the positive phase and its zero turns F off and leaves E on from the next cycle. The zero level that follows turns F on again.
- R5: A pulse of the wrong polarity, or a change of polarity with no zero between, turns both gates off from the next cycle and sets `fault[1]`. Recovery requires a fresh negative pulse followed by zero.
- R6: Both sync flags set in the same cycle is an invalid input and is handled exactly as in R5, including `fault[1]`.
- R7: The watchdog restarts on every change of the sync level (positive, negative or zero). If the level holds for `TIMEOUT_CYC` cycles while the sequencer is armed, both gates are off from `TIMEOUT_CYC`+2 cycles after the last change, and `fault[0]` is set.
- R8: A trip flag is ignored during the first `BLANK_CYC` cycles in which its gate is on. The window restarts on each turn-on of that gate.
- R9: A trip sampled after blanking turns off only its own gate, from the next cycle. That gate stays off until the next zero phase that would turn it on from off.
- R10: While `uvlo` is high both gates are off in the same cycle and `fault[2]` is set. After `uvlo` clears, a negative pulse followed by zero is required before the gates turn on.
- R11: The fault bits are sticky: once set, a bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pos | input | 1 | Sync is above the positive threshold |
| sync_neg | input | 1 | Sync is below the negative threshold |
| trip_e | input | 1 | Reverse-current trip for switch E |
| trip_f | input | 1 | Reverse-current trip for switch F |
| uvlo | input | 1 | Undervoltage lockout active |
| gate_e | output | 1 | Gate enable for switch E |
| gate_f | output | 1 | Gate enable for switch F |
| fault | output | 3 | Sticky fault flags: bit0 timeout, bit1 ordering, bit2 undervoltage |

## Verification
A wrong sequencer state shows up within one cycle of the next sync level. The wrong gate drops, a gate fails to return at zero, or `fault[1]` rises where the order was legal. A watchdog that misses a restart switches the gates off early, so the bench holds a level for just under the timeout and checks that the gates stay on. A blanking counter that is off by one shows up as a trip taking effect one cycle early or late around the window boundary.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic [2:0] {
        S_WAIT_NEG,
        S_WAIT_ZERO,
        S_ON_EXP_POS,
        S_POS,
        S_ON_EXP_NEG,
        S_NEG
    } sr_state_e;

    localparam int FLT_TIMEOUT = 0;
    localparam int FLT_ORDER   = 1;
    localparam int FLT_UV      = 2;
    localparam int FLT_W       = 3;
    localparam int NGATE       = 2;
endpackage

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
    import sr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pos,
    input  logic sync_neg,
    input  logic expire,
    input  logic uvlo,
    output logic allow_e,
    output logic allow_f,
    output logic order_err,
    output logic idle
);
    sr_state_e state, nxt;
    logic lvl_pos, lvl_neg, lvl_zero;

    assign lvl_pos  = sync_pos & ~sync_neg;
    assign lvl_neg  = sync_neg & ~sync_pos;
    assign lvl_zero = ~sync_pos & ~sync_neg;

    // next state and ordering check
    always_comb begin
        nxt       = state;
        order_err = 1'b0;
        unique case (state)
            S_WAIT_NEG:   if (lvl_neg) nxt = S_WAIT_ZERO;
            S_WAIT_ZERO:  if (lvl_zero) nxt = S_ON_EXP_POS;
                          else if (!lvl_neg) order_err = 1'b1;
            S_ON_EXP_POS: if (lvl_pos) nxt = S_POS;
                          else if (!lvl_zero) order_err = 1'b1;
            S_POS:        if (lvl_zero) nxt = S_ON_EXP_NEG;
                          else if (!lvl_pos) order_err = 1'b1;
            S_ON_EXP_NEG: if (lvl_neg) nxt = S_NEG;
                          else if (!lvl_zero) order_err = 1'b1;
            S_NEG:        if (lvl_zero) nxt = S_ON_EXP_POS;
                          else if (!lvl_neg) order_err = 1'b1;
            default:      nxt = S_WAIT_NEG;
        endcase
        if (order_err || expire || uvlo) nxt = S_WAIT_NEG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_WAIT_NEG;
        else        state <= nxt;
    end

    // gate permissions decoded from state
    always_comb begin
        allow_e = 1'b0;
        allow_f = 1'b0;
        idle    = 1'b0;
        unique case (state)
            S_WAIT_NEG:   idle = 1'b1;
            S_WAIT_ZERO:  ;
            S_ON_EXP_POS: begin allow_e = 1'b1; allow_f = 1'b1; end
            S_POS:        allow_f = 1'b1;
            S_ON_EXP_NEG: begin allow_e = 1'b1; allow_f = 1'b1; end
            S_NEG:        allow_e = 1'b1;
            default:      idle = 1'b1;
        endcase
    end

    p_both_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pos && sync_neg) |=> (state == S_WAIT_NEG));
    p_timeout_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == S_WAIT_NEG));
    p_uv_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (state == S_WAIT_NEG));
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ZERO && lvl_zero && !uvlo && !expire) |=> (allow_e && allow_f));
endmodule

// File: rtl/sr_watchdog.sv
module sr_watchdog #(
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_pos,
    input  logic sync_neg,
    input  logic idle,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    logic [1:0]    prev_lvl;
    logic [CW-1:0] cnt;
    logic          lvl_edge;

    assign lvl_edge = (prev_lvl != {sync_pos, sync_neg});
    assign expire   = (cnt == LIMIT) && !lvl_edge && !idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 2'b00;
            cnt      <= '0;
        end else begin
            prev_lvl <= {sync_pos, sync_neg};
            if (idle || lvl_edge)  cnt <= '0;
            else if (cnt != LIMIT) cnt <= cnt + 1'b1;
        end
    end

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_edge |=> !expire);
endmodule

// File: rtl/sr_gate_blank.sv
module sr_gate_blank #(
    parameter int BLANK_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic trip,
    output logic gate
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    logic          prev_allow, tripped, rise, blank;
    logic [BW-1:0] cnt;

    assign rise  = allow & ~prev_allow;
    assign blank = rise | (cnt != '0);
    assign gate  = allow & ~tripped;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_allow <= 1'b0;
            cnt        <= '0;
            tripped    <= 1'b0;
        end else begin
            prev_allow <= allow;
            if (rise)            cnt <= BW'(BLANK_CYC - 1);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
            if (!allow)                  tripped <= 1'b0;
            else if (!blank && trip)     tripped <= 1'b1;
        end
    end

    p_blank_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && blank) |=> !tripped);
    p_trip_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (allow && !blank && trip) |=> !gate);
    p_turn_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> gate);
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
    import sr_pkg::*;
#(
    parameter int BLANK_CYC   = 50,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pos,
    input  logic             sync_neg,
    input  logic             trip_e,
    input  logic             trip_f,
    input  logic             uvlo,
    output logic             gate_e,
    output logic             gate_f,
    output logic [FLT_W-1:0] fault
);
    logic             expire, order_err, idle;
    logic [NGATE-1:0] allow, trip, graw;
    logic [FLT_W-1:0] fault_q;

    sr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sync_pos(sync_pos), .sync_neg(sync_neg),
        .expire(expire), .uvlo(uvlo), .allow_e(allow[0]), .allow_f(allow[1]),
        .order_err(order_err), .idle(idle)
    );

    sr_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk(clk), .rst_n(rst_n), .sync_pos(sync_pos), .sync_neg(sync_neg),
        .idle(idle), .expire(expire)
    );

    assign trip = {trip_f, trip_e};

    for (genvar gi = 0; gi < NGATE; gi++) begin : g_gate
        sr_gate_blank #(.BLANK_CYC(BLANK_CYC)) u_gate (
            .clk(clk), .rst_n(rst_n), .allow(allow[gi]),
            .trip(trip[gi]), .gate(graw[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else begin
            if (expire)    fault_q[FLT_TIMEOUT] <= 1'b1;
            if (order_err) fault_q[FLT_ORDER]   <= 1'b1;
            if (uvlo)      fault_q[FLT_UV]      <= 1'b1;
        end
    end

    assign gate_e = graw[0] & ~uvlo;
    assign gate_f = graw[1] & ~uvlo;
    assign fault  = fault_q;

    p_uv_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (!gate_e && !gate_f));
    p_order_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> (!gate_e && !gate_f && fault[FLT_ORDER]));
    p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault & $past(fault)) == $past(fault)));
endmodule

// File: tb/sim_sr_gate_ctrl.sv
`timescale 1ns/100ps
module sim_sr_gate_ctrl;
    localparam int BLK = 3;
    localparam int TMO = 12;

    typedef struct {
        logic       e;
        logic       f;
        logic [2:0] flt;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_pos = 0, sync_neg = 0, trip_e = 0, trip_f = 0, uvlo = 0;
    logic gate_e, gate_f;
    logic [2:0] fault;
    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];
    exp_t it;

    always #2.5 clk = ~clk;

    sr_gate_ctrl #(.BLANK_CYC(BLK), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_pos(sync_pos), .sync_neg(sync_neg),
        .trip_e(trip_e), .trip_f(trip_f), .uvlo(uvlo),
        .gate_e(gate_e), .gate_f(gate_f), .fault(fault)
    );

    task automatic compare(input logic e, input logic f, input logic [2:0] flt, input string tag);
        checks++;
        if (gate_e !== e || gate_f !== f || fault !== flt) begin
            errors++;
            $display("FAIL %s: got e=%b f=%b fault=%b, expected e=%b f=%b fault=%b",
                     tag, gate_e, gate_f, fault, e, f, flt);
        end
    endtask

    // monitor: one expected item per cycle after each posedge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            compare(it.e, it.f, it.flt, it.tag);
        end
    end

    // driver: apply inputs for one cycle and queue the outputs expected after it
    task automatic step(input logic p, input logic n, input logic te, input logic tf,
                        input logic uv, input logic ee, input logic ef,
                        input logic [2:0] flt, input string tag);
        exp_t x;
        @(negedge clk);
        sync_pos = p; sync_neg = n; trip_e = te; trip_f = tf; uvlo = uv;
        x.e = ee; x.f = ef; x.flt = flt; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; sync_pos = 0; sync_neg = 0; trip_e = 0; trip_f = 0; uvlo = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(1'b0, 1'b0, 3'b000, "R1 reset state");
        rst_n = 1;
    endtask

    task automatic drain();
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        do_reset();
        // R1: ignore positive and zero before arming
        step(0,0,0,0,0, 0,0,3'b000, "R1 zero idle");
        step(1,0,0,0,0, 0,0,3'b000, "R1 pos ignored");
        step(0,1,0,0,0, 0,0,3'b000, "R1 neg arms");
        step(0,0,0,0,0, 1,1,3'b000, "R2 zero enables both");
        // R8: trip_e ignored in blanking
        for (int k = 0; k < BLK; k++)
            step(0,0,1,0,0, 1,1,3'b000, "R8 trip_e blanked");
        step(0,0,1,0,0, 0,1,3'b000, "R9 trip_e after blank");
        step(0,0,0,0,0, 0,1,3'b000, "R9 E stays tripped");
        step(1,0,0,0,0, 0,1,3'b000, "R3 pos E off F on");
        step(0,0,0,0,0, 1,1,3'b000, "R3 zero E back on");
        step(0,1,0,0,0, 1,0,3'b000, "R4 neg F off E on");
        step(0,0,0,0,0, 1,1,3'b000, "R4 zero F back on");
        for (int k = 0; k < BLK; k++)
            step(0,0,0,1,0, 1,1,3'b000, "R8 trip_f blanked");
        step(0,0,0,1,0, 1,0,3'b000, "R9 trip_f only F off");
        // R5: negative when positive expected
        step(0,1,0,0,0, 0,0,3'b010, "R5 wrong polarity");
        step(0,0,0,0,0, 0,0,3'b010, "R5 zero does not recover");
        step(0,1,0,0,0, 0,0,3'b010, "R5 neg rearm");
        step(0,0,0,0,0, 1,1,3'b010, "R11 recovered, fault sticky");
        // R5: polarity change without zero
        step(1,0,0,0,0, 0,1,3'b010, "R3 pos phase");
        step(0,1,0,0,0, 0,0,3'b010, "R5 pos to neg without zero");
        drain();

        // R6: both flags
        do_reset();
        step(0,1,0,0,0, 0,0,3'b000, "R6 arm");
        step(0,0,0,0,0, 1,1,3'b000, "R6 on");
        step(1,1,0,0,0, 0,0,3'b010, "R6 both flags fault");
        drain();

        // R7: watchdog restart, then timeout
        do_reset();
        step(0,1,0,0,0, 0,0,3'b000, "R7 arm");
        step(0,0,0,0,0, 1,1,3'b000, "R7 on");
        step(1,0,0,0,0, 0,1,3'b000, "R7 pos edge");
        for (int k = 1; k < TMO; k++)
            step(1,0,0,0,0, 0,1,3'b000, "R7 hold pos under timeout");
        step(0,0,0,0,0, 1,1,3'b000, "R7 edge restarts watchdog");
        for (int k = 0; k < TMO; k++)
            step(0,0,0,0,0, 1,1,3'b000, "R7 hold zero under timeout");
        step(0,0,0,0,0, 0,0,3'b001, "R7 timeout both off");
        step(0,0,0,0,0, 0,0,3'b001, "R11 timeout sticky");
        drain();

        // R10: undervoltage
        do_reset();
        step(0,1,0,0,0, 0,0,3'b000, "R10 arm");
        step(0,0,0,0,0, 1,1,3'b000, "R10 on");
        step(0,0,0,0,1, 0,0,3'b100, "R10 uvlo off");
        step(0,1,0,0,1, 0,0,3'b100, "R10 neg under uvlo");
        step(0,0,0,0,1, 0,0,3'b100, "R10 zero under uvlo");
        step(0,0,0,0,0, 0,0,3'b100, "R10 release needs rearm");
        step(0,1,0,0,0, 0,0,3'b100, "R10 rearm");
        step(0,0,0,0,0, 1,1,3'b100, "R10 on again");
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule